// File: doc/BRIEF.md
# Bridge Interrupt Status and Mask Unit

This unit gathers the event sources of a bus bridge into one 32-bit status register. Each bit has a fixed position. Descriptor-engine events sit in the low bits, the external device interrupt line is at bit 25, and a bus abort is at bit 26. Status bits are sticky: once an event sets a bit, it stays set until software writes a one to that bit.

A mask register has the same bit layout as the status register and selects which sources may raise the interrupt. A single global enable bit gates the combined interrupt output. The unit also presents the index of the lowest-numbered source that is both pending and unmasked, so the interrupt handler can dispatch it without scanning the status register.

Software reaches the three registers through a simple write strobe with address and data, and a combinational read-data path selected by the same address. Event inputs are one-cycle pulses, except the external interrupt line, which is a level.

Top module: `bridge_irq_ctrl`

## Requirements
- R1: After reset the status, mask and global enable registers all read zero, `irq_o` is low, `pend_vld_o` is low and `pend_idx_o` is zero.
- R2: The status register is at offset 0x00 and is write-one-to-clear. Writing a 1 to a bit clears that bit one clock later. Writing a 0 to a bit leaves it unchanged.
- R3: If an event for a bit arrives in the same cycle as a write-one-to-clear of that bit, the bit remains set.
- R4: Fixed event positions, set one clock after a pulse on the corresponding input:
  - inbound events `ib_evt_i[3:0]` (completed, ok, error, end-of-list) set status bits 3:0;
  - outbound events `ob_evt_i[3:0]` set bits 7:4;
  - `ib_ood_i` sets bit 9;
  - `bus_abort_i` sets bit 26.
- R5: Status bit 25 is set in every cycle that `ext_inta_i` is high. While the line stays high, clearing the bit has no effect. After the line drops, the bit stays set until it is cleared.
- R6: Status and mask bits outside the implemented set {0..7, 9, 25, 26} always read zero, and writes to them are ignored.
- R7: The mask register is at offset 0x04. It is read/write and has the same layout as the status register.
- R8: The global enable is bit 0 at offset 0x08. 1 enables the interrupt output and 0 disables it. The other bits of this register read zero.
- R9: `irq_o` is high exactly when the global enable is 1 and (status AND mask) is non-zero.
- R10: `pend_idx_o` is the position of the least significant set bit of (status AND mask), and `pend_vld_o` is high when that value is non-zero. When nothing is pending, `pend_vld_o` is low and `pend_idx_o` is zero.
- R11: Writes to any other offset change no register, and reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wen_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` (combinational) |
| ib_evt_i | input | 4 | Inbound descriptor event pulses |
| ob_evt_i | input | 4 | Outbound descriptor event pulses |
| ib_ood_i | input | 1 | Inbound out-of-descriptors pulse |
| ext_inta_i | input | 1 | External device interrupt level |
| bus_abort_i | input | 1 | Bus abort pulse |
| irq_o | output | 1 | Combined interrupt |
| pend_idx_o | output | IDX_W | Lowest pending unmasked source index |
| pend_vld_o | output | 1 | Pending index is valid |

## Verification
The bench builds the unit with its default parameters: a 32-bit data width and an 8-bit address. With these, every implemented status position and the unimplemented top bits 27 to 31 are reachable through writes of all ones. The 8-bit address reaches unused offsets such as 0x0C and 0x40. The full-width priority encoder can then be checked for the widest gap between pending sources (bit 9 to bit 26), and also with no pending source at all.

// File: rtl/bridge_irq_pkg.sv
package bridge_irq_pkg;
  // Status/mask bit positions, decoded by software
  localparam int BIT_IB_BASE = 0;
  localparam int BIT_OB_BASE = 4;
  localparam int BIT_IB_OOD  = 9;
  localparam int BIT_EXT     = 25;
  localparam int BIT_ABORT   = 26;
  // Positions that hold state; all others read zero
  localparam logic [31:0] IMPL_MAP = 32'h0600_02FF;
  // Register byte offsets
  localparam int OFS_STATUS = 'h00;
  localparam int OFS_MASK   = 'h04;
  localparam int OFS_GEN    = 'h08;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] stat_o
);
  import bridge_irq_pkg::*;
  localparam logic [DATA_W-1:0] IMPL = DATA_W'(IMPL_MAP);

  logic [DATA_W-1:0] stat_q, stat_d;
  logic              upd;

  // set dominates clear
  always_comb begin
    upd    = (|set_i) | (|clr_i);
    stat_d = ((stat_q & ~clr_i) | set_i) & IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  stat_q <= '0;
    else if (upd) stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  p_w1c_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((stat_q & $past(clr_i & ~set_i)) == '0));

  p_set_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & IMPL)) |=> ((stat_q & $past(set_i & IMPL)) == $past(set_i & IMPL)));

  p_unimpl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~IMPL) == '0));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic              gen_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o,
  output logic              gen_o
);
  import bridge_irq_pkg::*;
  localparam logic [DATA_W-1:0] IMPL = DATA_W'(IMPL_MAP);

  logic [DATA_W-1:0] mask_q, mask_d;
  logic              gen_q, gen_d;

  always_comb begin
    mask_d = wdata_i & IMPL;
    gen_d  = wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gen_q <= 1'b0;
    else if (gen_we_i) gen_q <= gen_d;
  end

  assign mask_o = mask_q;
  assign gen_o  = gen_q;

  p_mask_impl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_q & ~IMPL) == '0));
endmodule

// File: rtl/irq_low_enc.sv
module irq_low_enc #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] vec_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              vld_o
);
  // scan from the top down so the lowest set bit is the last one written
  always_comb begin
    idx_o = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
    vld_o = |vec_i;
  end
endmodule

// File: rtl/bridge_irq_ctrl.sv
module bridge_irq_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wen_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [3:0]        ib_evt_i,
  input  logic [3:0]        ob_evt_i,
  input  logic              ib_ood_i,
  input  logic              ext_inta_i,
  input  logic              bus_abort_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  pend_idx_o,
  output logic              pend_vld_o
);
  import bridge_irq_pkg::*;

  logic              sel_stat, sel_mask, sel_gen;
  logic [DATA_W-1:0] set_vec, clr_vec, stat, mask, pend;
  logic              gen_en;

  always_comb begin
    sel_stat = (reg_addr_i == ADDR_W'(OFS_STATUS));
    sel_mask = (reg_addr_i == ADDR_W'(OFS_MASK));
    sel_gen  = (reg_addr_i == ADDR_W'(OFS_GEN));
  end

  always_comb begin
    set_vec = '0;
    set_vec[BIT_IB_BASE +: 4] = ib_evt_i;
    set_vec[BIT_OB_BASE +: 4] = ob_evt_i;
    set_vec[BIT_IB_OOD]       = ib_ood_i;
    set_vec[BIT_EXT]          = ext_inta_i;
    set_vec[BIT_ABORT]        = bus_abort_i;
    clr_vec = (reg_wen_i && sel_stat) ? reg_wdata_i : '0;
  end

  irq_status_reg #(.DATA_W(DATA_W)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .stat_o(stat)
  );

  irq_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mask_we_i(reg_wen_i && sel_mask),
    .gen_we_i (reg_wen_i && sel_gen),
    .wdata_i  (reg_wdata_i),
    .mask_o   (mask),
    .gen_o    (gen_en)
  );

  assign pend = stat & mask;

  irq_low_enc #(.DATA_W(DATA_W)) u_enc (
    .vec_i(pend),
    .idx_o(pend_idx_o),
    .vld_o(pend_vld_o)
  );

  assign irq_o = gen_en & (|pend);

  always_comb begin
    if (sel_stat)      reg_rdata_o = stat;
    else if (sel_mask) reg_rdata_o = mask;
    else if (sel_gen)  reg_rdata_o = {{(DATA_W-1){1'b0}}, gen_en};
    else               reg_rdata_o = '0;
  end

  p_irq_has_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_vld_o);

  p_idx_lowest_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_vld_o |-> (stat[pend_idx_o] && mask[pend_idx_o]
                    && ((pend & ((DATA_W'(1) << pend_idx_o) - DATA_W'(1))) == '0)));

  p_idle_idx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_vld_o |-> (pend_idx_o == '0));
endmodule

// File: tb/bridge_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module bridge_irq_ctrl_tb_top;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int IW = $clog2(DW);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wen;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic [3:0]    ib_evt, ob_evt;
  logic          ood, inta, abort_p;
  logic          irq, vld;
  logic [IW-1:0] idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  bridge_irq_ctrl #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wen_i(wen), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ib_evt_i(ib_evt),
    .ob_evt_i(ob_evt), .ib_ood_i(ood), .ext_inta_i(inta),
    .bus_abort_i(abort_p), .irq_o(irq), .pend_idx_o(idx), .pend_vld_o(vld)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wen = 1'b1; addr = a; wdata = d;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [3:0] ib, input logic [3:0] ob, input logic o, input logic ab);
    @(negedge clk); ib_evt = ib; ob_evt = ob; ood = o; abort_p = ab;
    @(negedge clk); ib_evt = '0; ob_evt = '0; ood = 1'b0; abort_p = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rd(8'h00, v); check("R1 status", v, '0);
    rd(8'h04, v); check("R1 mask", v, '0);
    rd(8'h08, v); check("R1 enable", v, '0);
    check("R1 irq", DW'(irq), '0);
    check("R1 vld", DW'(vld), '0);
    check("R1 idx", DW'(idx), '0);
  endtask

  task automatic t_map();
    logic [DW-1:0] v;
    pulse(4'h5, 4'h0, 1'b0, 1'b0); rd(8'h00, v); check("R4 inbound", v, 32'h0000_0005);
    wr(8'h00, '1);
    pulse(4'h0, 4'hA, 1'b0, 1'b0); rd(8'h00, v); check("R4 outbound", v, 32'h0000_00A0);
    wr(8'h00, '1);
    pulse(4'h0, 4'h0, 1'b1, 1'b1); rd(8'h00, v); check("R4 ood+abort", v, 32'h0400_0200);
    wr(8'h00, '1);
  endtask

  task automatic t_w1c();
    logic [DW-1:0] v;
    pulse(4'hF, 4'hF, 1'b1, 1'b1);
    wr(8'h00, 32'h0400_0003); rd(8'h00, v); check("R2 partial clear", v, 32'h0000_02FC);
    wr(8'h00, 32'h0000_0000); rd(8'h00, v); check("R2 zero write", v, 32'h0000_02FC);
    wr(8'h00, '1); rd(8'h00, v); check("R2 full clear", v, '0);
  endtask

  task automatic t_collide_r3();
    logic [DW-1:0] v;
    @(negedge clk); wen = 1'b1; addr = 8'h00; wdata = 32'h1; ib_evt = 4'h1;
    @(negedge clk); wen = 1'b0; ib_evt = 4'h0;
    rd(8'h00, v); check("R3 set beats clear", v, 32'h1);
    wr(8'h00, '1);
  endtask

  task automatic t_ext_r5();
    logic [DW-1:0] v;
    @(negedge clk); inta = 1'b1;
    @(negedge clk); rd(8'h00, v); check("R5 level sets", v, 32'h0200_0000);
    wr(8'h00, 32'h0200_0000); rd(8'h00, v); check("R5 reasserts", v, 32'h0200_0000);
    @(negedge clk); inta = 1'b0;
    @(negedge clk); rd(8'h00, v); check("R5 sticky", v, 32'h0200_0000);
    wr(8'h00, 32'h0200_0000); rd(8'h00, v); check("R5 cleared", v, '0);
  endtask

  task automatic t_regs();
    logic [DW-1:0] v;
    wr(8'h04, '1); rd(8'h04, v); check("R6 R7 mask impl bits", v, 32'h0600_02FF);
    wr(8'h04, 32'h0000_0102); rd(8'h04, v); check("R7 mask rw", v, 32'h0000_0002);
    wr(8'h08, '1); rd(8'h08, v); check("R8 enable", v, 32'h1);
    wr(8'h08, '0); rd(8'h08, v); check("R8 disable", v, '0);
    wr(8'h00, '1); rd(8'h00, v); check("R6 status unimpl", v, '0);
    wr(8'h0C, '1); wr(8'h40, '1);
    rd(8'h04, v); check("R11 mask untouched", v, 32'h0000_0002);
    rd(8'h08, v); check("R11 enable untouched", v, '0);
    rd(8'h0C, v); check("R11 read zero", v, '0);
  endtask

  task automatic t_irq_prio();
    logic [DW-1:0] v;
    wr(8'h04, '1);
    pulse(4'h0, 4'h0, 1'b1, 1'b1);
    check("R9 disabled", DW'(irq), '0);
    check("R10 idx 9", DW'(idx), 32'd9);
    check("R10 vld", DW'(vld), 32'd1);
    wr(8'h08, 32'h1); check("R9 enabled", DW'(irq), 32'd1);
    wr(8'h00, 32'h200); check("R10 idx 26", DW'(idx), 32'd26);
    wr(8'h04, 32'h0000_00FF);
    check("R9 masked", DW'(irq), '0);
    check("R10 none vld", DW'(vld), '0);
    check("R10 none idx", DW'(idx), '0);
    rd(8'h00, v); check("R10 status kept", v, 32'h0400_0000);
    pulse(4'h0, 4'h8, 1'b0, 1'b0);
    check("R10 idx 7", DW'(idx), 32'd7); check("R9 raised", DW'(irq), 32'd1);
    wr(8'h08, '0); check("R9 gated", DW'(irq), '0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; wen = 1'b0; addr = '0; wdata = '0;
    ib_evt = '0; ob_evt = '0; ood = 1'b0; inta = 1'b0; abort_p = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_w1c();
    t_collide_r3();
    t_ext_r5();
    t_regs();
    t_irq_prio();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end
endmodule